// File: doc/BRIEF.md
# Host/Controller Mailbox Register Bank

This block is the register bank through which a host processor and an on-chip service controller exchange messages. It holds eight 64-bit mailbox words. The host writes a request into words 0 to 3. The controller writes its response into words 4 to 7. Every word is plain read/write storage on a word-addressed 64-bit bus port.

Two doorbells signal traffic between the two sides. The inbound doorbell carries one legal bit, "message waiting". When a bus write leaves that bit set, the bit clears itself at once and the block gives the command processor a single-cycle strobe. The outbound doorbell keeps six legal bits. A level interrupt to the host is high whenever any of those bits is set. The command logic may also OR bits into the outbound doorbell through a dedicated input.

Each doorbell has three addresses: a plain write, an AND-merge write and an OR-merge write. Bit numbers below count from the MSB, so bit n is data-bus bit 63-n.

Top module: `mbx_regfile`

## Requirements
- R1: While `rst_n` is low, all eight mailbox words and both doorbells are cleared, and `host_irq` and `msg_strobe` are low.
- R2: A write with `addr` 0 to 7 stores `wr_data` in that mailbox word. While `addr` holds that offset, `rd_data` shows the stored word in the same cycle.
- R3: Offsets other than 0x00-0x07 and 0x10-0x15 read as zero. Writes to them change no mailbox word and no doorbell.
- R4: A write to offset 0x13 replaces the outbound doorbell with `wr_data` masked to the legal bits. The legal bits are MSB-first bits 0-4 and 14, which is the mask 0xF802_0000_0000_0000. A read of 0x13 returns the doorbell.
- R5: A write to 0x14 stores the current outbound value ANDed with `wr_data`. A write to 0x15 stores it ORed with `wr_data`. The legal-bit mask applies in both cases.
- R6: `host_irq` is high exactly when the outbound doorbell is nonzero.
- R7: A write to 0x10 (plain) or 0x12 (OR) whose data bit 63 is set raises `msg_strobe` for exactly the next cycle. Every other data bit is discarded. A read of 0x10 always returns zero.
- R8: A write to 0x10 with data bit 63 clear does not raise `msg_strobe`. A write to the inbound AND alias at 0x11 never raises it, since the stored value is always zero.
- R9: Each cycle, the legal bits of `cmd_set` are ORed into the outbound doorbell. If a bus write to 0x13-0x15 happens in the same cycle, this OR is applied after the bus write result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current `addr` |
| addr | input | 6 | Word offset for read and write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data for `addr`, combinational |
| cmd_set | input | 64 | Bits the command logic ORs into the outbound doorbell |
| host_irq | output | 1 | Level interrupt to the host |
| msg_strobe | output | 1 | One-cycle message-waiting pulse to the command processor |

## Verification
The bench builds the bank with its default parameters: 64-bit words, eight mailbox words, and doorbell bases at 0x10 and 0x13. These values give the decoder every corner it has. A 6-bit address reaches unmapped offsets below, between and above the doorbell windows. The full legal-bit masks are exercised against all-ones and sparse patterns. Same-cycle collisions between the command-set input and the AND alias show the order in which the two updates are applied.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 64;
  // MSB-first bit 0 only
  localparam logic [WORD_W-1:0] IN_KEEP_DEF  = 64'h8000_0000_0000_0000;
  // MSB-first bits 0..4 and 14
  localparam logic [WORD_W-1:0] OUT_KEEP_DEF = 64'hF802_0000_0000_0000;

  typedef struct packed {
    logic rw;
    logic and_m;
    logic or_m;
  } bell_wr_t;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned W      = 64,
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] words
);
  for (genvar i = 0; i < N; i++) begin : g_word
    logic         en;
    logic [W-1:0] d;
    always_comb begin
      en = wr_en && (int'(addr) == i);
      d  = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  words[i] <= '0;
      else if (en) words[i] <= d;
    end
  end
endmodule

// File: rtl/mbx_bell.sv
module mbx_bell
  import mbx_pkg::*;
#(
  parameter int unsigned    W          = 64,
  parameter logic [W-1:0]   KEEP       = '1,
  parameter bit             SELF_CLEAR = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  bell_wr_t wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q,
  output logic         fire
);
  logic [W-1:0] base, merged, q_d;
  logic         en, fire_d;

  always_comb begin
    base = q;
    if (wr.rw)         base = wdata;
    else if (wr.and_m) base = q & wdata;
    else if (wr.or_m)  base = q | wdata;
    merged = (base | set_bits) & KEEP;
    en     = wr.rw | wr.and_m | wr.or_m | (|(set_bits & KEEP));
  end

  if (SELF_CLEAR) begin : g_pulse
    always_comb begin
      q_d    = '0;
      fire_d = en && (|merged);
    end
  end else begin : g_level
    always_comb begin
      q_d    = merged;
      fire_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      fire <= 1'b0;
    end else begin
      fire <= fire_d;
      if (en) q <= q_d;
    end
  end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int unsigned  W          = WORD_W,
  parameter int unsigned  MBOX_WORDS = 8,
  parameter int unsigned  ADDR_W     = 6,
  parameter int unsigned  IN_BASE    = 16,
  parameter int unsigned  OUT_BASE   = 19,
  parameter logic [W-1:0] IN_KEEP    = IN_KEEP_DEF,
  parameter logic [W-1:0] OUT_KEEP   = OUT_KEEP_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      cmd_set,
  output logic              host_irq,
  output logic              msg_strobe
);
  localparam logic [ADDR_W-1:0] IN_RW  = ADDR_W'(IN_BASE);
  localparam logic [ADDR_W-1:0] IN_AND = ADDR_W'(IN_BASE + 1);
  localparam logic [ADDR_W-1:0] IN_OR  = ADDR_W'(IN_BASE + 2);
  localparam logic [ADDR_W-1:0] OUT_RW  = ADDR_W'(OUT_BASE);
  localparam logic [ADDR_W-1:0] OUT_AND = ADDR_W'(OUT_BASE + 1);
  localparam logic [ADDR_W-1:0] OUT_OR  = ADDR_W'(OUT_BASE + 2);

  logic [MBOX_WORDS-1:0][W-1:0] mbox_words;
  logic [W-1:0] in_q, out_q;
  logic         out_fire;
  bell_wr_t     in_wr, out_wr;

  always_comb begin
    in_wr.rw     = wr_en && (addr == IN_RW);
    in_wr.and_m  = wr_en && (addr == IN_AND);
    in_wr.or_m   = wr_en && (addr == IN_OR);
    out_wr.rw    = wr_en && (addr == OUT_RW);
    out_wr.and_m = wr_en && (addr == OUT_AND);
    out_wr.or_m  = wr_en && (addr == OUT_OR);
  end

  mbx_store #(.W(W), .N(MBOX_WORDS), .ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wr_data), .words(mbox_words)
  );

  mbx_bell #(.W(W), .KEEP(IN_KEEP), .SELF_CLEAR(1'b1)) i_in_bell (
    .clk(clk), .rst_n(rst_n), .wr(in_wr), .wdata(wr_data),
    .set_bits('0), .q(in_q), .fire(msg_strobe)
  );

  mbx_bell #(.W(W), .KEEP(OUT_KEEP), .SELF_CLEAR(1'b0)) i_out_bell (
    .clk(clk), .rst_n(rst_n), .wr(out_wr), .wdata(wr_data),
    .set_bits(cmd_set), .q(out_q), .fire(out_fire)
  );

  always_comb begin
    rd_data = '0;
    if (int'(addr) < MBOX_WORDS) rd_data = mbox_words[addr[$clog2(MBOX_WORDS)-1:0]];
    else if (addr == IN_RW)      rd_data = in_q;
    else if (addr == OUT_RW)     rd_data = out_q;
    host_irq = |out_q;
  end

  logic unused_ok;
  assign unused_ok = out_fire;
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
  parameter int unsigned  W        = 64,
  parameter int unsigned  ADDR_W   = 6,
  parameter int unsigned  MBOX_WORDS = 8,
  parameter int unsigned  IN_BASE  = 16,
  parameter int unsigned  OUT_BASE = 19,
  parameter logic [W-1:0] OUT_KEEP = 64'hF802_0000_0000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      rd_data,
  input logic              host_irq,
  input logic              msg_strobe
);
  logic in_hit, unmapped;
  always_comb begin
    in_hit   = (int'(addr) == IN_BASE) || (int'(addr) == IN_BASE + 2);
    unmapped = (int'(addr) >= MBOX_WORDS) &&
               !((int'(addr) >= IN_BASE) && (int'(addr) <= OUT_BASE + 2));
  end

  // R7
  in_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_hit && wr_data[W-1]) |=> msg_strobe);
  // R8
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && in_hit && wr_data[W-1]) |=> !msg_strobe);
  // R7
  in_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) == IN_BASE) |-> (rd_data == '0));
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) == OUT_BASE) |-> (host_irq == (rd_data != '0)));
  // R4
  out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) == OUT_BASE) |-> ((rd_data & ~OUT_KEEP) == '0));
  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (rd_data == '0));
endmodule

bind mbx_regfile mbx_regfile_chk #(
  .W(W), .ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS), .IN_BASE(IN_BASE),
  .OUT_BASE(OUT_BASE), .OUT_KEEP(OUT_KEEP)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .host_irq(host_irq), .msg_strobe(msg_strobe)
);

// File: tb/test_mbx_regfile.sv
`timescale 1ns/1ps
module test_mbx_regfile;
  localparam logic [63:0] KEEP = 64'hF802_0000_0000_0000;
  localparam logic [63:0] MW   = 64'h8000_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [63:0] wr_data = '0, cmd_set = '0, rd_data;
  logic host_irq, msg_strobe;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mbx_regfile i_mbx_regfile (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cmd_set(cmd_set),
    .host_irq(host_irq), .msg_strobe(msg_strobe));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [63:0] exp);
    @(negedge clk); addr = a; #0.5;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd_chk("R1", 6'(i), '0);
    rd_chk("R1", 6'h13, '0);
    check("R1", {63'd0, host_irq}, 64'd0);
    check("R1", {63'd0, msg_strobe}, 64'd0);
  endtask

  task automatic t_mbox;
    for (int i = 0; i < 8; i++) wr(6'(i), 64'h1111_0000_0000_0000 * (i + 1) + 64'(i));
    for (int i = 0; i < 8; i++) rd_chk("R2", 6'(i), 64'h1111_0000_0000_0000 * (i + 1) + 64'(i));
  endtask

  task automatic t_unmapped;
    wr(6'h08, '1); wr(6'h16, '1); wr(6'h3F, '1); wr(6'h0F, '1);
    rd_chk("R3", 6'h08, '0); rd_chk("R3", 6'h16, '0); rd_chk("R3", 6'h3F, '0);
    rd_chk("R3", 6'h13, '0);
    check("R3", {63'd0, host_irq}, 64'd0);
    rd_chk("R3", 6'h07, 64'h1111_0000_0000_0000 * 8 + 64'd7);
  endtask

  task automatic t_out_rw;
    wr(6'h13, '1);
    rd_chk("R4", 6'h13, KEEP);
    check("R6", {63'd0, host_irq}, 64'd1);
    wr(6'h13, ~KEEP);
    rd_chk("R4", 6'h13, '0);
    check("R6", {63'd0, host_irq}, 64'd0);
  endtask

  task automatic t_out_alias;
    wr(6'h13, 64'h8800_0000_0000_0000);
    wr(6'h15, 64'h4002_0000_0000_FFFF);
    rd_chk("R5", 6'h13, 64'hC802_0000_0000_0000);
    wr(6'h14, 64'h4802_FFFF_FFFF_FFFF);
    rd_chk("R5", 6'h13, 64'h4802_0000_0000_0000);
    wr(6'h14, '0);
    rd_chk("R5", 6'h13, '0);
    check("R6", {63'd0, host_irq}, 64'd0);
  endtask

  task automatic t_in_bell;
    wr(6'h10, MW);
    check("R7", {63'd0, msg_strobe}, 64'd1);
    @(negedge clk); check("R7", {63'd0, msg_strobe}, 64'd0);
    rd_chk("R7", 6'h10, '0);
    wr(6'h10, ~MW);
    check("R8", {63'd0, msg_strobe}, 64'd0);
    wr(6'h12, '1);
    check("R7", {63'd0, msg_strobe}, 64'd1);
    wr(6'h11, '1);
    check("R8", {63'd0, msg_strobe}, 64'd0);
    rd_chk("R7", 6'h10, '0);
  endtask

  task automatic t_cmd_set;
    @(negedge clk); cmd_set = '1;
    @(negedge clk); cmd_set = '0;
    rd_chk("R9", 6'h13, KEEP);
    check("R9", {63'd0, host_irq}, 64'd1);
    @(negedge clk); wr_en = 1'b1; addr = 6'h14; wr_data = '0; cmd_set = 64'h0002_0000_0000_0001;
    @(negedge clk); wr_en = 1'b0; cmd_set = '0;
    rd_chk("R9", 6'h13, 64'h0002_0000_0000_0000);
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_n = 1'b0; #0.5;
    check("R1", {63'd0, host_irq}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1", 6'h03, '0);
    rd_chk("R1", 6'h13, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_mbox; t_unmapped; t_out_rw; t_out_alias; t_in_bell; t_cmd_set; t_reset_again;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errors++; $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule